// File: doc/BRIEF.md
# Synchronous Flash Command Sequencer

This block connects a simple host request port to a synchronous flash device that is driven over an SDRAM-style command bus. Each accepted host request becomes a fixed three-command sequence on the device bus. The first command loads the device command register, the second is Active and the third is Write or Read. A host write is turned into a program sequence. A host read is turned into a status-register read, and the returned 8-bit status byte is handed back to the host.

Requests follow a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole sequence, which is the block's only form of back-pressure. A host may hold `req_valid` high while the block is busy; that request is simply not taken until ready returns. The response side has no back-pressure. `rsp_done` is a single-cycle pulse, and on a read it comes with the status byte, zero-extended, on `rsp_data`. The row-to-column gap and the CAS latency come from plain configuration pins. Their values are captured when a request is accepted.

Top module: `sfc_seq`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the cycle in which `rsp_done` pulses. A request presented while `req_ready` is low does not change the sequence in progress.
- R2: In the cycle after acceptance the command bus {cs_n,ras_n,cas_n,we_n} is 4'b0000 (command-register load). In that cycle `fl_addr[7:0]` is 8'h40 for a write or 8'h70 for a read, `fl_addr[11:8]` is row bits [11:8], and `fl_ba` is the request bank.
- R3: The next cycle carries Active (4'b0011), with `fl_addr` equal to the row and `fl_ba` equal to the bank of the preceding command-register load.
- R4: Between Active and the column command there are exactly N cycles of NOP (4'b0111), where N is `cfg_trcd`, and a value of 0 is treated as 1.
- R5: A write's column command is 4'b0100, with `fl_addr` equal to the zero-extended column, the bank on `fl_ba`, and `fl_dq_oe` high with `fl_dq_out` equal to the write data. `fl_dq_oe` is low in every other cycle.
- R6: The cycle after a Write is a NOP, never a burst terminate. `rsp_done` pulses in that cycle and `req_ready` is high in it.
- R7: A read's column command is 4'b0101, with the zero-extended column and the bank. The status byte is sampled from `fl_dq_in[7:0]` in the CL-th cycle after Read, where CL is 2 when `cfg_cl3`=0 and 3 when it is 1. In the following cycle `rsp_done` pulses and `rsp_data` = {8'h00, status}.
- R8: The host address is split as column = `req_addr[7:0]`, row = `req_addr[19:8]` and bank = `req_addr[21:20]`.
- R9: `rsp_done` is never high for two cycles in a row. The command bus is NOP in every cycle in which the block is idle.
- R10: During reset and right after it, the command bus is NOP, `fl_dq_oe` and `rsp_done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = program, 0 = status read |
| req_addr | input | 22 | Host address {bank,row,col} |
| req_wdata | input | 16 | Data to program |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Zero-extended status byte on read completion |
| cfg_trcd | input | 2 | Row-to-column NOP cycles (0 acts as 1) |
| cfg_cl3 | input | 1 | CAS latency select: 0 = 2, 1 = 3 |
| fl_cs_n | output | 1 | Device chip select |
| fl_ras_n | output | 1 | Row strobe |
| fl_cas_n | output | 1 | Column strobe |
| fl_we_n | output | 1 | Write enable |
| fl_ba | output | 2 | Bank address |
| fl_addr | output | 12 | Device address bus |
| fl_dq_out | output | 16 | Write data toward the device |
| fl_dq_oe | output | 1 | Data driver enable |
| fl_dq_in | input | 16 | Data from the device |

## Verification
The bench sweeps both operation types against every row-to-column setting (including the 0-acts-as-1 case) and both CAS latencies. The addresses it uses put distinct patterns in the bank, row and column fields, so that a swapped or shifted field shows up on the address bus. During a read, the device model drives the true status only in the CL-th cycle after Read and drives its complement, with a nonzero upper byte, in all other cycles. An off-by-one latency therefore produces a wrong byte, and a missing zero-extension produces a wrong upper byte. Some runs keep a second request asserted while the block is busy, which separates a correct ready gate from one that lets a new sequence begin early.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef logic [3:0] cmd_t;  // {cs_n, ras_n, cas_n, we_n}
  localparam cmd_t CMD_LCR = 4'b0000;
  localparam cmd_t CMD_ACT = 4'b0011;
  localparam cmd_t CMD_RD  = 4'b0101;
  localparam cmd_t CMD_WR  = 4'b0100;
  localparam cmd_t CMD_NOP = 4'b0111;
  localparam logic [7:0] OP_PROG = 8'h40;
  localparam logic [7:0] OP_STAT = 8'h70;
  typedef enum logic [2:0] {S_IDLE, S_LCR, S_ACT, S_GAP, S_COL, S_LAT} st_t;
endpackage

// File: rtl/sfc_addr_split.sv
module sfc_addr_split #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  localparam int HADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [HADDR_W-1:0] haddr,
  output logic [BANK_W-1:0]  bank,
  output logic [ROW_W-1:0]   row,
  output logic [COL_W-1:0]   col
);
  assign col  = haddr[COL_W-1:0];
  assign row  = haddr[COL_W +: ROW_W];
  assign bank = haddr[HADDR_W-1 -: BANK_W];
endmodule

// File: rtl/sfc_fsm.sv
module sfc_fsm
  import sfc_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_wr,
  input  logic [CNT_W-1:0] gap_len,
  input  logic [CNT_W-1:0] lat_len,
  output st_t              state,
  output logic             cap,
  output logic             wr_end
);
  logic [CNT_W-1:0] cnt;

  assign cap    = (state == S_LAT) && (cnt == lat_len);
  assign wr_end = (state == S_COL) && is_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) state <= S_LCR;
        S_LCR:  state <= S_ACT;
        S_ACT: begin
          state <= S_GAP;
          cnt   <= CNT_W'(1);
        end
        S_GAP: begin
          if (cnt == gap_len) state <= S_COL;
          else cnt <= cnt + CNT_W'(1);
        end
        S_COL: begin
          if (is_wr) state <= S_IDLE;
          else begin
            state <= S_LAT;
            cnt   <= CNT_W'(1);
          end
        end
        S_LAT: begin
          if (cnt == lat_len) state <= S_IDLE;
          else cnt <= cnt + CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfc_bus_mux.sv
module sfc_bus_mux
  import sfc_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8
) (
  input  st_t               state,
  input  logic              is_wr,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output cmd_t              cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic              oe
);
  always_comb begin
    cmd  = CMD_NOP;
    ba   = bank;
    addr = '0;
    oe   = 1'b0;
    case (state)
      S_LCR: begin
        cmd  = CMD_LCR;
        addr = {row[ROW_W-1:8], (is_wr ? OP_PROG : OP_STAT)};
      end
      S_ACT: begin
        cmd  = CMD_ACT;
        addr = row;
      end
      S_COL: begin
        cmd  = is_wr ? CMD_WR : CMD_RD;
        addr = {{(ROW_W-COL_W){1'b0}}, col};
        oe   = is_wr;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  localparam int HADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [HADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_done,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic [1:0]         cfg_trcd,
  input  logic               cfg_cl3,
  output logic               fl_cs_n,
  output logic               fl_ras_n,
  output logic               fl_cas_n,
  output logic               fl_we_n,
  output logic [BANK_W-1:0]  fl_ba,
  output logic [ROW_W-1:0]   fl_addr,
  output logic [DATA_W-1:0]  fl_dq_out,
  output logic               fl_dq_oe,
  input  logic [DATA_W-1:0]  fl_dq_in
);
  localparam int CNT_W = 2;

  logic [BANK_W-1:0] in_bank, r_bank;
  logic [ROW_W-1:0]  in_row, r_row;
  logic [COL_W-1:0]  in_col, r_col;
  logic [DATA_W-1:0] r_wdata;
  logic              r_wr;
  logic [CNT_W-1:0]  r_gap, r_lat;
  logic              start, cap, wr_end;
  st_t               state;
  cmd_t              cmd;

  assign req_ready = (state == S_IDLE);
  assign start     = req_valid && req_ready;

  sfc_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .haddr(req_addr), .bank(in_bank), .row(in_row), .col(in_col)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_bank  <= '0;
      r_row   <= '0;
      r_col   <= '0;
      r_wdata <= '0;
      r_wr    <= 1'b0;
      r_gap   <= CNT_W'(1);
      r_lat   <= CNT_W'(2);
    end else if (start) begin
      r_bank  <= in_bank;
      r_row   <= in_row;
      r_col   <= in_col;
      r_wdata <= req_wdata;
      r_wr    <= req_write;
      r_gap   <= (cfg_trcd == 2'd0) ? CNT_W'(1) : CNT_W'(cfg_trcd);
      r_lat   <= cfg_cl3 ? CNT_W'(3) : CNT_W'(2);
    end
  end

  sfc_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .is_wr(r_wr),
    .gap_len(r_gap), .lat_len(r_lat), .state(state), .cap(cap), .wr_end(wr_end)
  );

  sfc_bus_mux #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_mux (
    .state(state), .is_wr(r_wr), .bank(r_bank), .row(r_row), .col(r_col),
    .cmd(cmd), .ba(fl_ba), .addr(fl_addr), .oe(fl_dq_oe)
  );

  assign {fl_cs_n, fl_ras_n, fl_cas_n, fl_we_n} = cmd;
  assign fl_dq_out = r_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_done <= 1'b0;
      rsp_data <= '0;
    end else begin
      rsp_done <= cap || wr_end;
      if (cap) rsp_data <= {{(DATA_W-8){1'b0}}, fl_dq_in[7:0]};
    end
  end
endmodule

// File: rtl/sfc_seq_chk.sv
module sfc_seq_chk #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              fl_cs_n,
  input logic              fl_ras_n,
  input logic              fl_cas_n,
  input logic              fl_we_n,
  input logic [BANK_W-1:0] fl_ba,
  input logic [ROW_W-1:0]  fl_addr,
  input logic              fl_dq_oe
);
  logic [3:0] c;
  assign c = {fl_cs_n, fl_ras_n, fl_cas_n, fl_we_n};

  p_accept_lcr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (c == 4'b0000));
  p_lcr_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0000) |-> (fl_addr[7:0] == 8'h40 || fl_addr[7:0] == 8'h70));
  p_act_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0000) |=> (c == 4'b0011 && fl_ba == $past(fl_ba)));
  p_oe_only_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_dq_oe |-> (c == 4'b0100));
  p_wr_has_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0100) |-> fl_dq_oe);
  p_no_burst_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c == 4'b0100) |=> (c == 4'b0111 && rsp_done && req_ready));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_idle_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (c == 4'b0111));
endmodule

bind sfc_seq sfc_seq_chk #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .fl_cs_n(fl_cs_n), .fl_ras_n(fl_ras_n),
  .fl_cas_n(fl_cas_n), .fl_we_n(fl_we_n), .fl_ba(fl_ba), .fl_addr(fl_addr),
  .fl_dq_oe(fl_dq_oe)
);

// File: tb/sfc_seq_bench.sv
module sfc_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_data;
  logic [1:0]  cfg_trcd = 2'd1;
  logic        cfg_cl3 = 1'b0;
  logic        fl_cs_n, fl_ras_n, fl_cas_n, fl_we_n;
  logic [1:0]  fl_ba;
  logic [11:0] fl_addr;
  logic [15:0] fl_dq_out;
  logic        fl_dq_oe;
  logic [15:0] fl_dq_in = 16'h0;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  sfc_seq u_sfc_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .cfg_trcd(cfg_trcd),
    .cfg_cl3(cfg_cl3), .fl_cs_n(fl_cs_n), .fl_ras_n(fl_ras_n),
    .fl_cas_n(fl_cas_n), .fl_we_n(fl_we_n), .fl_ba(fl_ba), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  wire [3:0] cmd = {fl_cs_n, fl_ras_n, fl_cas_n, fl_we_n};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic run_op(bit wr, logic [21:0] a, logic [15:0] d, int trcd, bit cl3, bit noisy);
    logic [7:0] st;
    int n, cl;
    st = a[7:0] ^ d[15:8] ^ 8'h3C;
    n  = (trcd == 0) ? 1 : trcd;
    cl = cl3 ? 3 : 2;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    cfg_trcd = 2'(trcd); cfg_cl3 = cl3;
    @(negedge clk);  // command-register load cycle
    req_valid = noisy;
    if (noisy) begin req_addr = ~a; req_write = ~wr; cfg_trcd = 2'd3; cfg_cl3 = ~cl3; end
    chk("R1 ready low", 32'(req_ready), 0);
    chk("R2 cmd load", 32'(cmd), 32'h0);
    chk("R2 opcode", 32'(fl_addr[7:0]), wr ? 32'h40 : 32'h70);
    chk("R2 upper row", 32'(fl_addr[11:8]), 32'(a[19:16]));
    chk("R8 bank", 32'(fl_ba), 32'(a[21:20]));
    @(negedge clk);  // Active
    chk("R3 cmd act", 32'(cmd), 32'h3);
    chk("R3 row", 32'(fl_addr), 32'(a[19:8]));
    chk("R3 bank", 32'(fl_ba), 32'(a[21:20]));
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R4 gap nop", 32'(cmd), 32'h7);
      chk("R5 oe low", 32'(fl_dq_oe), 0);
    end
    @(negedge clk);  // column command
    req_valid = 0;
    fl_dq_in = {8'h99, ~st};
    chk(wr ? "R5 cmd wr" : "R7 cmd rd", 32'(cmd), wr ? 32'h4 : 32'h5);
    chk("R8 col", 32'(fl_addr), 32'(a[7:0]));
    chk("R8 col bank", 32'(fl_ba), 32'(a[21:20]));
    chk("R5 oe", 32'(fl_dq_oe), 32'(wr));
    if (wr) chk("R5 wdata", 32'(fl_dq_out), 32'(d));
    if (wr) begin
      @(negedge clk);
      chk("R6 nop after wr", 32'(cmd), 32'h7);
      chk("R6 done", 32'(rsp_done), 1);
      chk("R1 ready back", 32'(req_ready), 1);
    end else begin
      for (int k = 1; k <= cl; k++) begin
        @(negedge clk);
        fl_dq_in = (k == cl) ? {8'hEE, st} : {8'h99, ~st};
        chk("R7 wait nop", 32'(cmd), 32'h7);
        chk("R7 no early done", 32'(rsp_done), 0);
      end
      @(negedge clk);
      fl_dq_in = {8'h99, ~st};
      chk("R7 done", 32'(rsp_done), 1);
      chk("R7 status", 32'(rsp_data), 32'({8'h00, st}));
      chk("R1 ready back", 32'(req_ready), 1);
    end
    @(negedge clk);
    chk("R9 done one cycle", 32'(rsp_done), 0);
    chk("R9 idle nop", 32'(cmd), 32'h7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset nop", 32'(cmd), 32'h7);
    chk("R10 reset oe", 32'(fl_dq_oe), 0);
    chk("R10 reset done", 32'(rsp_done), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ready", 32'(req_ready), 1);
    chk("R10 idle nop", 32'(cmd), 32'h7);
    for (int w = 0; w < 2; w++)
      for (int t = 0; t < 4; t++)
        for (int c = 0; c < 2; c++)
          for (int p = 0; p < 4; p++) begin
            logic [21:0] a;
            logic [15:0] d;
            a = {2'(p), 12'h0A5 + 12'(p * 12'h351 + t * 7), 8'h1E ^ 8'(p * 37 + c * 91)};
            d = 16'hC35A ^ 16'(p * 16'h1111 + t * 3 + w * 16'h0F0F);
            run_op(w[0], a, d, t, c[0], p[0]);
          end
    finish_run();
  end
endmodule